// File: doc/BRIEF.md
# Stepped-clock CPU bootstrap loader

This block fills an external static RAM for an 8-bit processor that has no boot ROM. It does this by using the processor as its own address generator. The sequencer holds the processor in reset and then gives it single clock pulses on a stepped clock. A buffer enable keeps the processor's read and write strobes away from the RAM. Each time the processor starts an opcode fetch, the sequencer takes the next boot byte from a valid/ready stream. It puts the byte on the data bus and pulses the RAM write strobe low, so the byte is stored at the address the processor is driving. The sequencer then places the no-operation opcode 0x00 on the bus and keeps stepping the clock until the fetch ends. The processor executes that no-op and moves on to the next address.

When the requested number of bytes is stored, the processor is reset a second time. The buffer enable is then released and `done_o` rises. A clock multiplexer outside the block uses `done_o` to switch the processor over to the free-running clock. If the processor never starts a fetch, a pulse-count timeout stops the sequence and raises an error flag.

Top module: `boot_loader_seq`

## Requirements
- R1: While `rst_ni` is low, and afterwards until a start, the block drives the following levels. `cpu_rst_no` is 0 and `cpu_clk_o` is 0. `ram_we_no` is 1. `buf_iso_o`, `data_oe_o`, `byte_ready_o`, `done_o` and `error_o` are all 0.
- R2: A start pulse in the idle, done or error state latches `len_i` and begins the sequence. The processor reset is held low for exactly RST_PULSES rising edges of `cpu_clk_o` (default 8) and then released. `buf_iso_o` is already 1 when the processor begins its first read.
- R3: In each processor read, the sequencer drives boot byte k on `data_o`. It pulses `ram_we_no` low for WE_CYC system cycles while `cpu_rd_ni` is low and the stepped clock is still. Byte k is stored at processor address k, and k counts up from 0.
- R4: After each write, the sequencer drives 0x00 and keeps pulsing the clock until `cpu_rd_ni` returns high. Every opcode the processor fetches during loading is therefore 0x00.
- R5: `data_oe_o` is 1 only while `cpu_rd_ni` is low and `buf_iso_o` is 1.
- R6: `byte_ready_o` is 1 only while the sequencer waits inside a processor read. While the sequencer waits for `byte_valid_i`, no clock pulse is issued.
- R7: After the last byte, the processor gets a second reset of RST_PULSES pulses. After that reset, `cpu_rst_no` is 1, `buf_iso_o` is 0, `done_o` is 1, and the stepped clock stays low.
- R8: If TIMEOUT clock pulses (default 64) pass with no read, `error_o` goes to 1 and the processor is held in reset. A later start clears the error and runs a complete sequence.
- R9: A length of 0 skips the loading loop. No write is made, and the second reset follows at once.
- R10: A start pulse is ignored while a sequence is in progress, and so is a change of `len_i` during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a boot sequence |
| len_i | input | LW (14) | Number of boot bytes, up to MAX_LEN |
| byte_i | input | 8 | Boot byte from the stream |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_ready_o | output | 1 | Sequencer accepts a byte |
| cpu_rd_ni | input | 1 | Processor read strobe, active low |
| cpu_rst_no | output | 1 | Processor reset, active low |
| cpu_clk_o | output | 1 | Stepped processor clock |
| data_o | output | 8 | Value for the processor data bus |
| data_oe_o | output | 1 | Data bus drive enable |
| ram_we_no | output | 1 | RAM write strobe, active low |
| buf_iso_o | output | 1 | Strobe buffer disable (1 = processor strobes cut from RAM) |
| done_o | output | 1 | Loading finished, free-running clock may take over |
| error_o | output | 1 | Timeout waiting for a processor read |

## Verification
Each stepped pulse spans four system cycles: one cycle high, one low, one cycle to report, and one idle cycle. The sequencer checks `cpu_rd_ni` on the report cycle. A byte is accepted on the clock edge after `byte_ready_o` and `byte_valid_i` are both seen at a falling edge. `ram_we_no` falls two edges later and stays low WE_CYC cycles. The bench does not predict these offsets as fixed counts. A processor and RAM model reacts to `cpu_clk_o` edges and write-strobe edges, and the scoreboard compares each stored address and byte at the rising edge of the strobe, where data must still be valid. Reset-length and timeout checks count stepped edges between the edges of `cpu_rst_no`.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_A,
    ST_ISOLATE,
    ST_FETCH,
    ST_GET,
    ST_WR_SETUP,
    ST_WR_LOW,
    ST_WR_HOLD,
    ST_NOP,
    ST_RST_B,
    ST_DONE,
    ST_FAULT
  } seq_state_e;

  function automatic int cnt_w(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/boot_count.sv
module boot_count #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/boot_step_clk.sv
module boot_step_clk #(
  parameter int HALF = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic clk_o,
  output logic pulse_done_o
);

  localparam int HW = (HALF < 2) ? 1 : $clog2(HALF);

  logic          busy_q;
  logic          high_q;
  logic          done_q;
  logic [HW-1:0] cnt_q;

  // one-cycle gap after done_q lets the sequencer decide before the next pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      high_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_i && !done_q) begin
          busy_q <= 1'b1;
          high_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (cnt_q == HW'(HALF - 1)) begin
        cnt_q <= '0;
        if (high_q) begin
          high_q <= 1'b0;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + HW'(1);
      end
    end
  end

  assign clk_o        = high_q;
  assign pulse_done_o = done_q;

  assert_pulse_on_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(high_q) |-> $past(req_i));

endmodule

// File: rtl/boot_loader_seq.sv
module boot_loader_seq
  import boot_seq_pkg::*;
#(
  parameter int MAX_LEN    = 8192,
  parameter int DW         = 8,
  parameter int RST_PULSES = 8,
  parameter int TIMEOUT    = 64,
  parameter int WE_CYC     = 2,
  parameter int HALF       = 1,
  localparam int LW        = cnt_w(MAX_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic [DW-1:0] byte_i,
  input  logic          byte_valid_i,
  output logic          byte_ready_o,
  input  logic          cpu_rd_ni,
  output logic          cpu_rst_no,
  output logic          cpu_clk_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          ram_we_no,
  output logic          buf_iso_o,
  output logic          done_o,
  output logic          error_o
);

  localparam int CMAX0 = (RST_PULSES > TIMEOUT) ? RST_PULSES : TIMEOUT;
  localparam int CMAX  = (CMAX0 > WE_CYC) ? CMAX0 : WE_CYC;
  localparam int CW    = cnt_w(CMAX);

  seq_state_e    state_q, state_d;
  logic [LW-1:0] len_q;
  logic [DW-1:0] byte_q;
  logic [CW-1:0] pcnt;
  logic [LW-1:0] bcnt;
  logic          pulse_req, pulse_done;
  logic          start_ok, byte_take, byte_end, drive;

  boot_step_clk #(.HALF(HALF)) u_step (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (pulse_req),
    .clk_o        (cpu_clk_o),
    .pulse_done_o (pulse_done)
  );

  // pulses in reset/fetch/nop phases, cycles in the write-low phase
  boot_count #(.W(CW)) u_pcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != state_d),
    .inc_i  (pulse_done || (state_q == ST_WR_LOW)),
    .cnt_o  (pcnt)
  );

  boot_count #(.W(LW)) u_bcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .inc_i  (byte_end),
    .cnt_o  (bcnt)
  );

  assign start_ok  = start_i && (state_q inside {ST_IDLE, ST_DONE, ST_FAULT});
  assign byte_take = (state_q == ST_GET) && byte_valid_i;
  assign byte_end  = (state_q == ST_NOP) && pulse_done && cpu_rd_ni;

  always_comb begin
    state_d   = state_q;
    pulse_req = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAULT: if (start_i) state_d = ST_RST_A;
      ST_RST_A: begin
        pulse_req = 1'b1;
        if (pulse_done && pcnt == CW'(RST_PULSES - 1)) state_d = ST_ISOLATE;
      end
      ST_ISOLATE: state_d = (len_q == '0) ? ST_RST_B : ST_FETCH;
      ST_FETCH: begin
        pulse_req = 1'b1;
        if (pulse_done) begin
          if (!cpu_rd_ni)                      state_d = ST_GET;
          else if (pcnt == CW'(TIMEOUT - 1))   state_d = ST_FAULT;
        end
      end
      ST_GET:      if (byte_valid_i) state_d = ST_WR_SETUP;
      ST_WR_SETUP: state_d = ST_WR_LOW;
      ST_WR_LOW:   if (pcnt == CW'(WE_CYC - 1)) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  state_d = ST_NOP;
      ST_NOP: begin
        pulse_req = 1'b1;
        if (byte_end) state_d = ((bcnt + LW'(1)) == len_q) ? ST_RST_B : ST_FETCH;
      end
      ST_RST_B: begin
        pulse_req = 1'b1;
        if (pulse_done && pcnt == CW'(RST_PULSES - 1)) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_ok)  len_q  <= len_i;
      if (byte_take) byte_q <= byte_i;
    end
  end

  assign drive        = state_q inside {ST_WR_SETUP, ST_WR_LOW, ST_WR_HOLD, ST_NOP};
  assign cpu_rst_no   = !(state_q inside {ST_IDLE, ST_RST_A, ST_RST_B, ST_FAULT});
  assign buf_iso_o    = state_q inside {ST_ISOLATE, ST_FETCH, ST_GET, ST_WR_SETUP,
                                        ST_WR_LOW, ST_WR_HOLD, ST_NOP, ST_RST_B};
  assign data_o       = (state_q == ST_NOP) ? '0 : byte_q;
  assign data_oe_o    = drive && !cpu_rd_ni;
  assign ram_we_no    = (state_q != ST_WR_LOW);
  assign byte_ready_o = (state_q == ST_GET);
  assign done_o       = (state_q == ST_DONE);
  assign error_o      = (state_q == ST_FAULT);

  assert_ready_noclk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> !cpu_clk_o);

  assert_we_in_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> (!cpu_rd_ni && !cpu_clk_o && buf_iso_o));

  assert_oe_isolated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> buf_iso_o);

  assert_done_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cpu_clk_o && ram_we_no));

  assert_fault_no_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> $past(cpu_rd_ni));

endmodule

// File: tb/boot_loader_seq_bench.sv
`timescale 1ns/1ps
module boot_loader_seq_bench;

  localparam int RSTP = 8;
  localparam int TMO  = 64;
  localparam int LW   = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          start_i;
  logic [LW-1:0] len_i;
  logic [7:0]    byte_i;
  logic          byte_valid_i;
  logic          byte_ready_o;
  logic          cpu_rd_n;
  logic          cpu_rst_no, cpu_clk_o, data_oe_o, ram_we_no, buf_iso_o, done_o, error_o;
  logic [7:0]    data_o;

  int total = 0, bad = 0;
  int rst_edges = 0, run_edges = 0, reads = 0, writes = 0;
  int op_bad = 0, iso_bad = 0, we_bad = 0, oe_bad = 0, stall_bad = 0;
  int addr = 0, ph = 0;
  bit cpu_dead = 0;
  int rst_snap[$];
  int exp_q[$];

  always #10 clk_i = ~clk_i;

  boot_loader_seq u_boot_loader_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .byte_i(byte_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
    .cpu_rd_ni(cpu_rd_n), .cpu_rst_no(cpu_rst_no), .cpu_clk_o(cpu_clk_o),
    .data_o(data_o), .data_oe_o(data_oe_o), .ram_we_no(ram_we_no),
    .buf_iso_o(buf_iso_o), .done_o(done_o), .error_o(error_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // processor model: fetch cycle of four stepped edges
  initial begin
    cpu_rd_n = 1'b1;
    forever begin
      @(posedge cpu_clk_o);
      if (!cpu_rst_no) begin
        rst_edges++; ph = 0; addr = 0; cpu_rd_n <= 1'b1;
      end else begin
        run_edges++;
        if (!cpu_dead) begin
          case (ph)
            0: ph = 1;
            1: begin cpu_rd_n <= 1'b0; if (!buf_iso_o) iso_bad++; ph = 2; end
            2: begin
              if (!(data_oe_o && data_o == 8'h00)) op_bad++;
              reads++; cpu_rd_n <= 1'b1; addr++; ph = 3;
            end
            default: ph = 0;
          endcase
        end
      end
    end
  end

  initial forever begin
    @(posedge cpu_rst_no);
    rst_snap.push_back(rst_edges);
    rst_edges = 0;
  end

  // RAM monitor / scoreboard
  initial forever begin
    @(negedge ram_we_no);
    if (cpu_rd_n) we_bad++;
    @(posedge ram_we_no);
    writes++;
    if (exp_q.size() == 0) check(1'b0, "R3", "unexpected write addr", addr, -1);
    else begin
      int e;
      e = exp_q.pop_front();
      check(data_oe_o && ((addr << 8) | data_o) == e, "R3", "ram write {addr,data}",
            (addr << 8) | data_o, e);
    end
  end

  initial forever begin
    @(negedge clk_i);
    if (data_oe_o && (cpu_rd_n || !buf_iso_o)) oe_bad++;
    if (byte_ready_o && cpu_clk_o) stall_bad++;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic clear_counts();
    rst_snap.delete(); exp_q.delete();
    rst_edges = 0; run_edges = 0; reads = 0; writes = 0;
  endtask

  task automatic pulse_start(input int n);
    @(negedge clk_i); len_i = LW'(n); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic drive_bytes(input int n, input int seed, input int gap, input bit poke);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 37) ^ (i << 3));
      exp_q.push_back((i << 8) | b);
      while (!byte_ready_o) @(negedge clk_i);
      if (gap > 0) begin
        int e0;
        e0 = run_edges;
        repeat (gap) @(negedge clk_i);
        check(run_edges == e0 && !cpu_clk_o, "R6", "clock moved while stalled",
              run_edges, e0);
      end
      byte_i = b; byte_valid_i = 1'b1;
      @(negedge clk_i);
      byte_valid_i = 1'b0;
      if (poke && i == 1) begin
        len_i = LW'(3); start_i = 1'b1;
        @(negedge clk_i); start_i = 1'b0;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic wait_end();
    while (!done_o && !error_o) @(negedge clk_i);
  endtask

  task automatic run_boot(input int n, input int seed, input int gap, input bit poke);
    clear_counts();
    pulse_start(n);
    fork
      drive_bytes(n, seed, gap, poke);
      wait_end();
    join
    check(done_o && !error_o, "R7", "done flag", done_o, 1);
    check(writes == n && exp_q.size() == 0, poke ? "R10" : "R3", "write count", writes, n);
    check(reads == n && op_bad == 0, "R4", "no-op fetch count", reads, n);
    check(rst_snap.size() == 2, "R7", "reset releases", rst_snap.size(), 2);
    if (rst_snap.size() == 2) begin
      check(rst_snap[0] == RSTP, "R2", "first reset pulses", rst_snap[0], RSTP);
      check(rst_snap[1] == RSTP, "R7", "second reset pulses", rst_snap[1], RSTP);
    end
    begin
      int e0;
      e0 = run_edges;
      repeat (16) @(negedge clk_i);
      check(cpu_rst_no && !buf_iso_o && run_edges == e0 && !cpu_clk_o, "R7",
            "handoff state", {cpu_rst_no, buf_iso_o, cpu_clk_o}, 3'b100);
    end
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; len_i = '0; byte_i = '0; byte_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check({cpu_rst_no, cpu_clk_o, ram_we_no, buf_iso_o, data_oe_o, byte_ready_o, done_o, error_o}
          == 8'b0010_0000, "R1", "reset outputs",
          {cpu_rst_no, cpu_clk_o, ram_we_no, buf_iso_o, data_oe_o, byte_ready_o, done_o, error_o},
          8'b0010_0000);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(!cpu_rst_no && !cpu_clk_o && !buf_iso_o, "R1", "idle after reset",
          {cpu_rst_no, cpu_clk_o, buf_iso_o}, 0);

    run_boot(12, 5, 0, 0);
    run_boot(6, 91, 7, 0);
    run_boot(5, 200, 0, 1);
    run_boot(0, 0, 0, 0);
    check(writes == 0 && reads == 0, "R9", "zero length no traffic", writes + reads, 0);

    // timeout: processor never reads
    clear_counts();
    cpu_dead = 1'b1;
    pulse_start(4);
    wait_end();
    check(error_o && !done_o && !cpu_rst_no, "R8", "timeout state",
          {error_o, done_o, cpu_rst_no}, 3'b100);
    check(run_edges == TMO, "R8", "pulses before timeout", run_edges, TMO);
    cpu_dead = 1'b0;
    run_boot(3, 17, 2, 0);
    check(!error_o, "R8", "error cleared by restart", error_o, 0);

    check(iso_bad == 0, "R2", "isolation before read", iso_bad, 0);
    check(we_bad == 0, "R3", "strobe outside read", we_bad, 0);
    check(oe_bad == 0, "R5", "bus driven outside read", oe_bad, 0);
    check(stall_bad == 0, "R6", "clock high while ready", stall_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule